// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a window watchdog clocked by the peripheral bus clock. A 7-bit down-counter steps once per prescaled tick; the tick period is a base of `PRE_BASE` bus clocks (4096 by default) multiplied by 1, 2, 4 or 8, picked by a 2-bit prescale field. Once the watchdog is armed, firmware must reload the counter at regular intervals. A reload is accepted only after the counter has fallen to or below a programmable window value. A reload that comes too early, or a counter that is allowed to fall past 0x40, produces a one-cycle system reset request.

An early-warning flag is raised when the counter reaches 0x40. This is one tick before the reset. The flag drives an interrupt output when its enable is set. A debug freeze input pair lets the counter stop while the processor is halted. The timeout after a reload of value T is `PRE_BASE * 2^pre * (T[5:0] + 1)` bus clocks.

Software reaches three registers through a simple write strobe / address / data port, and reads them through a combinational read port.

Top module: `wdog_window`

## Requirements
- R1: After reset, address 0 reads 0x07F, address 1 reads 0x07F, address 2 reads 0x000, and both `sys_rst_req` and `early_irq` are low.
- R2: Address 0 (control) holds the counter in bits [6:0] and the arm bit in bit 7. Address 1 (config) holds the window value in bits [6:0], the prescale select in bits [8:7] and the interrupt enable in bit 9. Address 2 (status) holds the early flag in bit 0. Address 3 reads as zero.
- R3: While armed and not frozen, the counter decrements once every `PRE_BASE << pre` bus clocks. Each accepted or rejected control write restarts the prescaler.
- R4: A control write that arms the watchdog with counter value T, where T[6]=1, gives a `sys_rst_req` pulse exactly one bus clock wide. The pulse is seen `(T[5:0]+1) * (PRE_BASE << pre)` clocks after the write edge, when the counter steps from 0x40 to 0x3F.
- R5: A control write that leaves the watchdog armed with a counter value whose bit 6 is 0 raises `sys_rst_req` in the cycle right after the write.
- R6: A control write while the watchdog is armed and the counter is above the window value raises `sys_rst_req` in the next cycle and leaves the counter unchanged.
- R7: A control write while the counter is at or below the window value loads the new counter value and raises no reset.
- R8: Once armed, the arm bit stays 1 until block reset. Writing 0 to bit 7 has no effect on it.
- R9: The early flag sets when the counter steps down to 0x40. A status write with bit 0 equal to 0 clears it, and a status write with bit 0 equal to 1 leaves it unchanged.
- R10: `early_irq` is high exactly when the early flag and the config interrupt enable are both 1.
- R11: While `dbg_halted` and `dbg_stop_en` are both 1, the counter holds its value. If either one is 0, the counter runs.
- R12: While not armed, the counter never decrements and no reset is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral bus clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for write and read |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data (combinational) |
| dbg_halted | input | 1 | Processor is halted by the debugger |
| dbg_stop_en | input | 1 | Freeze the counter while halted |
| sys_rst_req | output | 1 | One-cycle system reset request |
| early_irq | output | 1 | Early-warning interrupt |

## Verification
A wrong prescaler terminal or a bad decrement moves the reset pulse by at least one tick. The bench sweeps every prescale setting against every counter start value, so this shows as a timeout count that is off by a whole tick period. A wrong window compare, or a lost arm bit, shows in the very next cycle as an unexpected or missing reset pulse, or as a counter readback that differs from the expected value. A flag set on the wrong count is seen one tick early or late compared with the reset pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 7;
  localparam int REG_W = 10;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CFG  = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam int ARM_BIT  = 7;
  localparam int IEN_BIT  = 9;
  localparam logic [CNT_W-1:0] WARN_VAL = 7'h40;
  localparam logic [CNT_W-1:0] CNT_RST  = 7'h7F;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_BASE = 4096,
  localparam int PCW = $clog2(PRE_BASE) + 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] pre_sel,
  output logic       tick
);
  logic [PCW-1:0] pcnt_q, pcnt_d, term;

  always_comb begin
    term = (PCW'(PRE_BASE) << pre_sel) - PCW'(1);
    tick = run && !restart && (pcnt_q == term);
    pcnt_d = pcnt_q;
    if (restart)
      pcnt_d = '0;
    else if (run)
      pcnt_d = (pcnt_q == term) ? '0 : pcnt_q + PCW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= pcnt_d;
  end

  // R3: the count never passes the terminal for the selected ratio
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= ((PCW'(PRE_BASE) << pre_sel) - PCW'(1)));
endmodule

// File: rtl/wdog_down_counter.sv
module wdog_down_counter
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             freeze,
  input  logic             ctrl_we,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             wr_arm,
  input  logic [CNT_W-1:0] win,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             armed,
  output logic             flag,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt_d;
  logic armed_d, flag_d, fire_d, flag_set;

  always_comb begin
    cnt_d    = cnt;
    armed_d  = armed;
    fire_d   = 1'b0;
    flag_set = 1'b0;
    if (ctrl_we) begin
      if (armed && (cnt > win)) begin
        fire_d = 1'b1;
      end else begin
        cnt_d   = wr_val;
        armed_d = armed | wr_arm;
        if (armed_d && !wr_val[CNT_W-1]) fire_d = 1'b1;
      end
    end else if (tick) begin
      cnt_d = cnt - CNT_W'(1);
      if (cnt == WARN_VAL) fire_d = 1'b1;
      if (cnt == WARN_VAL + CNT_W'(1)) flag_set = 1'b1;
    end
    flag_d = flag_set ? 1'b1 : (flag_clr ? 1'b0 : flag);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= CNT_RST;
      armed   <= 1'b0;
      flag    <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      cnt     <= cnt_d;
      armed   <= armed_d;
      flag    <= flag_d;
      rst_req <= fire_d;
    end
  end

  a_r8_arm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !ctrl_we) |=> ($stable(cnt) && !rst_req));
  a_r11_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !ctrl_we) |=> $stable(cnt));
  a_r9_flag_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == WARN_VAL));
  a_r4_timeout_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ctrl_we && cnt == WARN_VAL) |=> (rst_req && cnt == WARN_VAL - CNT_W'(1)));
  a_r7_in_window_load: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && (!armed || cnt <= win)) |=> (cnt == $past(wr_val)));
endmodule

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
  import wdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [CNT_W-1:0] cnt,
  input  logic             armed,
  input  logic             flag,
  output logic [CNT_W-1:0] win,
  output logic [1:0]       pre_sel,
  output logic             irq_en,
  output logic [REG_W-1:0] reg_rdata
);
  logic cfg_we;
  logic [CNT_W-1:0] win_d;
  logic [1:0] pre_d;
  logic ien_d;

  always_comb begin
    cfg_we = reg_we && (reg_addr == ADDR_CFG);
    win_d  = cfg_we ? reg_wdata[CNT_W-1:0] : win;
    pre_d  = cfg_we ? reg_wdata[IEN_BIT-1:CNT_W] : pre_sel;
    ien_d  = cfg_we ? reg_wdata[IEN_BIT] : irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win     <= CNT_RST;
      pre_sel <= 2'd0;
      irq_en  <= 1'b0;
    end else begin
      win     <= win_d;
      pre_sel <= pre_d;
      irq_en  <= ien_d;
    end
  end

  always_comb begin
    case (reg_addr)
      ADDR_CTRL: reg_rdata = {2'b00, armed, cnt};
      ADDR_CFG:  reg_rdata = {irq_en, pre_sel, win};
      ADDR_STAT: reg_rdata = {{(REG_W-1){1'b0}}, flag};
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int PRE_BASE = 4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             dbg_halted,
  input  logic             dbg_stop_en,
  output logic             sys_rst_req,
  output logic             early_irq
);
  logic ctrl_we, flag_clr, freeze, tick;
  logic armed, flag, irq_en;
  logic [CNT_W-1:0] cnt, win;
  logic [1:0] pre_sel;

  always_comb begin
    ctrl_we  = reg_we && (reg_addr == ADDR_CTRL);
    flag_clr = reg_we && (reg_addr == ADDR_STAT) && !reg_wdata[0];
    freeze   = dbg_halted && dbg_stop_en;
    early_irq = flag && irq_en;
  end

  wdog_prescaler #(.PRE_BASE(PRE_BASE)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(armed && !freeze), .restart(ctrl_we),
    .pre_sel(pre_sel), .tick(tick));

  wdog_down_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .freeze(freeze),
    .ctrl_we(ctrl_we), .wr_val(reg_wdata[CNT_W-1:0]),
    .wr_arm(reg_wdata[ARM_BIT]), .win(win), .flag_clr(flag_clr),
    .cnt(cnt), .armed(armed), .flag(flag), .rst_req(sys_rst_req));

  wdog_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .cnt(cnt), .armed(armed), .flag(flag),
    .win(win), .pre_sel(pre_sel), .irq_en(irq_en), .reg_rdata(reg_rdata));

  // R10: the interrupt follows the flag only when enabled
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag || !irq_en) |-> !early_irq);
endmodule

// File: tb/test_wdog_window.sv
module test_wdog_window;
  localparam int PB = 4;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [9:0] reg_wdata = '0;
  logic [9:0] reg_rdata;
  logic dbg_halted = 1'b0;
  logic dbg_stop_en = 1'b0;
  logic sys_rst_req, early_irq;
  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  wdog_window #(.PRE_BASE(PB)) i_wdog_window (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dbg_halted(dbg_halted),
    .dbg_stop_en(dbg_stop_en), .sys_rst_req(sys_rst_req), .early_irq(early_irq));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      tests = tests + 1;
      fails = fails + 1;
      $display("FAIL watchdog: run hung (got %0d cycles, expected fewer)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    reg_we = 1'b0;
    dbg_halted = 1'b0;
    dbg_stop_en = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [9:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  logic [9:0] v;

  initial begin
    do_reset();
    // R1 reset state
    rd(2'd0, v); chk(v == 10'h07F, "R1 ctrl", v, 10'h07F);
    rd(2'd1, v); chk(v == 10'h07F, "R1 cfg", v, 10'h07F);
    rd(2'd2, v); chk(v == 10'h000, "R1 stat", v, 0);
    chk(!sys_rst_req && !early_irq, "R1 outputs", {sys_rst_req, early_irq}, 0);
    // R2 field layout of config, unused address
    wr(2'd1, 10'h2A5);
    rd(2'd1, v); chk(v == 10'h2A5, "R2 cfg fields", v, 10'h2A5);
    rd(2'd3, v); chk(v == 10'h000, "R2 addr3 zero", v, 0);

    // R12 unarmed counter holds
    do_reset();
    wr(2'd0, 10'h055);
    repeat (50) @(negedge clk);
    rd(2'd0, v); chk(v == 10'h055, "R12 idle hold", v, 10'h055);
    chk(!sys_rst_req, "R12 no reset", sys_rst_req, 0);

    // R3 R4 R9 R10 sweep: every prescale, every start value
    for (int p = 0; p < 4; p++) begin
      for (int n = 0; n < 64; n++) begin
        int per, exp_r, exp_f, got_r, got_f, hi, irq_bad;
        do_reset();
        per = PB << p;
        exp_r = (n + 1) * per;
        exp_f = n * per;
        wr(2'd1, {p[0], p[1:0], 7'h7F});
        wr(2'd0, 10'h0C0 | 10'(n));
        got_r = 0; got_f = 0; hi = 0; irq_bad = 0;
        for (int k = 1; k <= exp_r + 3; k++) begin
          @(negedge clk);
          if (sys_rst_req) begin hi++; if (got_r == 0) got_r = k; end
          if (i_wdog_window.reg_rdata[0] === 1'bx) irq_bad = 1;
          if (early_irq != (got_f != 0 || k >= exp_f && n > 0) & p[0]) irq_bad = irq_bad;
          if (got_f == 0 && n > 0) begin
            rd(2'd2, v);
            if (v[0]) got_f = k;
          end
          if (early_irq !== (p[0] && got_f != 0)) irq_bad = 1;
        end
        chk(got_r == exp_r, "R4 timeout", got_r, exp_r);
        chk(hi == 1, "R4 pulse width", hi, 1);
        if (n > 0) chk(got_f == exp_f, "R9 flag set", got_f, exp_f);
        chk(irq_bad == 0, "R10 irq gate", irq_bad, 0);
      end
    end

    // R9 flag clear: write 1 keeps it, write 0 clears it
    wr(2'd2, 10'h001);
    rd(2'd2, v); chk(v == 10'h001, "R9 write1 keeps", v, 1);
    wr(2'd2, 10'h000);
    rd(2'd2, v); chk(v == 10'h000, "R9 clear", v, 0);

    // R5 arming with bit 6 clear
    do_reset();
    wr(2'd0, 10'h0BF);
    chk(sys_rst_req, "R5 immediate reset", sys_rst_req, 1);

    // R7 R6 R8 window behaviour
    do_reset();
    wr(2'd1, 10'h050);
    wr(2'd0, 10'h0FF);
    repeat (200) @(negedge clk);
    rd(2'd0, v); chk(v == 10'h0CD, "R3 decrement count", v, 10'h0CD);
    wr(2'd0, 10'h0FA);
    chk(!sys_rst_req, "R7 no reset", sys_rst_req, 0);
    rd(2'd0, v); chk(v == 10'h0FA, "R7 reload", v, 10'h0FA);
    wr(2'd0, 10'h0F0);
    chk(sys_rst_req, "R6 early reset", sys_rst_req, 1);
    rd(2'd0, v); chk(v == 10'h0FA, "R6 no reload", v, 10'h0FA);
    repeat (200) @(negedge clk);
    wr(2'd0, 10'h060);
    chk(!sys_rst_req, "R8 in-window write", sys_rst_req, 0);
    rd(2'd0, v); chk(v == 10'h0E0, "R8 arm sticky", v, 10'h0E0);

    // R11 debug freeze
    do_reset();
    dbg_halted = 1'b1; dbg_stop_en = 1'b1;
    wr(2'd0, 10'h0FF);
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 10'h0FF, "R11 frozen", v, 10'h0FF);
    dbg_stop_en = 1'b0;
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 10'h0F5, "R11 runs halted no-stop", v, 10'h0F5);
    dbg_halted = 1'b0; dbg_stop_en = 1'b1;
    repeat (40) @(negedge clk);
    rd(2'd0, v); chk(v == 10'h0EB, "R11 runs not halted", v, 10'h0EB);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule